// File: doc/BRIEF.md
# Scanline Reversal Buffer

This block takes a stream of pixels, at most one per clock, grouped into scanlines of `N` pixels. It sends each scanline back out in mirrored order, with the last pixel first. A stereo pipeline can use it to scan a line from the opposite side, or to restore the original order after such a scan, so that two streams stay in phase.

The block has two line-sized RAM banks. While the incoming line is written into one bank at ascending addresses, the line completed just before it is read from the other bank at descending addresses. The roles swap each time a line completes. When the last pixel of a line is captured, the reversed line follows on the next cycles at one pixel per clock. Back-to-back lines therefore leave as an unbroken stream with no loss of throughput.

Top module: `scanline_reverser`

## Requirements
- R1: Within each completed line, the k-th output pixel (k counted from 0) equals the input pixel that held position N-1-k in that line.
- R2: The first reversed pixel of a line is presented one clock after the edge that captures that line's last input pixel. The remaining N-1 pixels follow on consecutive cycles with `outValid` high, and `outValid` is low on every other cycle.
- R3: `outSol` is high together with the first reversed pixel of each line and low on every other cycle.
- R4: No output is valid until the first line after reset has been fully written.
- R5: Lines that arrive back to back at one pixel per clock leave as a continuous stream, with `outValid` held high across line boundaries.
- R6: Idle input cycles (`inValid` low) inside a line pause the write position only. Reading of the previously completed line continues at one pixel per clock.
- R7: A pixel that has `inValid` and `inSol` both high is stored at position 0 of a new line. Any unfinished partial line is dropped and never appears at the output.
- R8: While `rstN` is low, `outValid` and `outSol` are low.
- R9: `inPix` and `inSol` have no effect on a cycle where `inValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inPix | input | PIX_W | Incoming pixel |
| inValid | input | 1 | Incoming pixel is valid this cycle |
| inSol | input | 1 | With inValid: pixel is the first of a line |
| outPix | output | PIX_W | Reversed pixel |
| outValid | output | 1 | outPix is valid this cycle |
| outSol | output | 1 | outPix is the first pixel of a reversed line |

## Verification
Every output pixel is due at a fixed offset from one event, the edge that captures the last pixel of its line. Reversed pixel k is due exactly k+1 clocks after that edge. When the bench's model sees a line complete, it writes the expected valid flag, start flag and pixel value into a ring of slots indexed by that future cycle number. After every clock edge the bench compares the outputs with the slot for that cycle and then clears it, so a result that arrives early, late or twice shows up as a mismatch.

// File: rtl/lrev_pkg.sv
package lrev_pkg;

  // Strobes passed from the line controller to the datapath
  typedef struct packed {
    logic wrEn;     // store inPix this cycle
    logic wrBank;   // bank receiving the current line
    logic rdEn;     // fetch one reversed pixel this cycle
    logic rdBank;   // bank holding the completed line
    logic rdFirst;  // fetched pixel opens a reversed line
  } lrev_strb_t;

endpackage

// File: rtl/lrev_ctrl.sv
module lrev_ctrl
  import lrev_pkg::*;
#(
  parameter int LINE_LEN = 640,
  localparam int AW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inSol,
  output lrev_strb_t    strb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr
);

  localparam logic [AW-1:0] LAST = AW'(LINE_LEN - 1);

  logic [AW-1:0] wrCnt;
  logic          wrBank;
  logic          rdActive;
  logic [AW-1:0] rdCnt;
  logic [AW-1:0] slotIdx;
  logic          lineDone;

  // A start-of-line pixel always lands at position 0
  assign slotIdx  = inSol ? '0 : wrCnt;
  assign lineDone = inValid && (slotIdx == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCnt    <= '0;
      wrBank   <= 1'b0;
      rdActive <= 1'b0;
      rdCnt    <= '0;
    end else begin
      if (inValid) begin
        wrCnt <= lineDone ? '0 : slotIdx + 1'b1;
      end
      if (lineDone) begin
        wrBank   <= ~wrBank;
        rdActive <= 1'b1;
        rdCnt    <= LAST;
      end else if (rdActive) begin
        if (rdCnt == '0) rdActive <= 1'b0;
        else             rdCnt    <= rdCnt - 1'b1;
      end
    end
  end

  always_comb begin
    strb.wrEn    = inValid;
    strb.wrBank  = wrBank;
    strb.rdEn    = rdActive;
    strb.rdBank  = ~wrBank;
    strb.rdFirst = rdActive && (rdCnt == LAST);
  end

  assign wrAddr = slotIdx;
  assign rdAddr = rdCnt;

  // R6: a line can only complete once the previous readout has drained
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |-> (!rdActive || rdCnt == '0));

  // R1: readout always ends at address 0
  a_r1_read_ends_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdActive) |-> ($past(rdCnt) == '0));

  // R7: the write position stays inside the line
  a_r7_write_in_line: assert property (@(posedge clk) disable iff (!rstN)
    wrCnt <= LAST);

  initial begin
    a_r1_line_len: assert (LINE_LEN >= 2);
  end

endmodule

// File: rtl/lrev_datapath.sv
module lrev_datapath
  import lrev_pkg::*;
#(
  parameter int LINE_LEN = 640,
  parameter int PIX_W    = 8,
  localparam int AW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1,
  localparam int NBANK = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  lrev_strb_t       strb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [PIX_W-1:0] inPix,
  output logic [PIX_W-1:0] outPix,
  output logic             outValid,
  output logic             outSol
);

  logic [PIX_W-1:0] bankQ [NBANK];
  logic             selQ;

  for (genvar b = 0; b < NBANK; b++) begin : gBank
    logic [PIX_W-1:0] mem [LINE_LEN];
    logic [PIX_W-1:0] q;

    always_ff @(posedge clk) begin
      if (strb.wrEn && (strb.wrBank == 1'(b))) begin
        mem[wrAddr] <= inPix;
      end
      if (strb.rdEn && (strb.rdBank == 1'(b))) begin
        q <= mem[rdAddr];
      end
    end

    assign bankQ[b] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSol   <= 1'b0;
      selQ     <= 1'b0;
    end else begin
      outValid <= strb.rdEn;
      outSol   <= strb.rdFirst;
      selQ     <= strb.rdBank;
    end
  end

  assign outPix = bankQ[selQ];

  // R3: a line start is always a valid pixel
  a_r3_sol_is_valid: assert property (@(posedge clk) disable iff (!rstN)
    outSol |-> outValid);

  // R3: line starts never sit on adjacent cycles
  a_r3_sol_isolated: assert property (@(posedge clk) disable iff (!rstN)
    outSol |=> !outSol);

  // R2: every burst of output opens with a line start
  a_r2_burst_opens: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> outSol);

  // R6: the bank being read is never the one being written
  a_r6_bank_split: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.wrEn) |-> (strb.rdBank != strb.wrBank));

endmodule

// File: rtl/scanline_reverser.sv
module scanline_reverser
  import lrev_pkg::*;
#(
  parameter int LINE_LEN = 640,
  parameter int PIX_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_W-1:0] inPix,
  input  logic             inValid,
  input  logic             inSol,
  output logic [PIX_W-1:0] outPix,
  output logic             outValid,
  output logic             outSol
);

  localparam int AW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;

  lrev_strb_t    strb;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;

  lrev_ctrl #(.LINE_LEN(LINE_LEN)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inSol   (inSol),
    .strb    (strb),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr)
  );

  lrev_datapath #(.LINE_LEN(LINE_LEN), .PIX_W(PIX_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .inPix    (inPix),
    .outPix   (outPix),
    .outValid (outValid),
    .outSol   (outSol)
  );

endmodule

// File: tb/scanline_reverser_test.sv
module scanline_reverser_test;

  localparam int CLK_PERIOD = 10;
  localparam int N    = 8;
  localparam int W    = 8;
  localparam int RING = 64;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] inPix = '0;
  logic         inValid = 1'b0;
  logic         inSol = 1'b0;
  logic [W-1:0] outPix;
  logic         outValid;
  logic         outSol;

  scanline_reverser #(.LINE_LEN(N), .PIX_W(W)) uut (
    .clk(clk), .rstN(rstN), .inPix(inPix), .inValid(inValid), .inSol(inSol),
    .outPix(outPix), .outValid(outValid), .outSol(outSol)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  string ph = "R8";

  logic         expV [RING];
  logic         expS [RING];
  logic [W-1:0] expP [RING];
  logic [W-1:0] lineBuf [N];
  int           mCnt = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s) cycle %0d: actual %0h expected %0h", tag, ph, cyc, act, exp);
    end
  endtask

  // compare outputs after the latest edge with the slot scheduled for it
  task automatic checkSlot();
    int s;
    s = cyc % RING;
    chk("R2", int'(outValid), int'(expV[s]));
    chk("R3", int'(outSol), int'(expS[s]));
    if (expV[s]) chk("R1", int'(outPix), int'(expP[s]));
    expV[s] = 1'b0;
    expS[s] = 1'b0;
  endtask

  // drive one cycle (called just after a falling edge), update the model
  task automatic drive(input logic v, input logic s, input logic [W-1:0] p);
    int idx;
    int edgeNo;
    inValid = v;
    inSol   = s;
    inPix   = p;
    if (v) begin
      idx = s ? 0 : mCnt;
      lineBuf[idx] = p;
      if (idx == N - 1) begin
        edgeNo = cyc + 1;
        for (int j = 0; j < N; j++) begin
          expV[(edgeNo + 1 + j) % RING] = 1'b1;
          expS[(edgeNo + 1 + j) % RING] = (j == 0);
          expP[(edgeNo + 1 + j) % RING] = lineBuf[N - 1 - j];
        end
        mCnt = 0;
      end else begin
        mCnt = idx + 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    checkSlot();
  endtask

  task automatic sendLine(input int gapPct);
    for (int k = 0; k < N; k++) begin
      while (($urandom % 100) < gapPct) begin
        drive(1'b0, 1'($urandom), W'($urandom));   // R9 noise while idle
      end
      drive(1'b1, (k == 0), W'($urandom));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < RING; i++) begin
      expV[i] = 1'b0;
      expS[i] = 1'b0;
      expP[i] = '0;
    end

    // R8: reset state, with input activity that must be ignored
    inValid = 1'b1;
    inSol   = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8", int'(outValid), 0);
      chk("R8", int'(outSol), 0);
    end
    inValid = 1'b0;
    inSol   = 1'b0;
    rstN    = 1'b1;

    // R4: first line, directed ramp, nothing out while it is written
    ph = "R4";
    for (int k = 0; k < N; k++) drive(1'b1, (k == 0), W'(8'h10 + k));

    // R5: back-to-back random lines
    ph = "R5";
    for (int l = 0; l < 4; l++) sendLine(0);

    // R6 / R9: lines with idle gaps and noise on idle cycles
    ph = "R6";
    for (int l = 0; l < 5; l++) sendLine(35);

    // R7: partial line aborted by a new line start
    ph = "R7";
    for (int k = 0; k < 3; k++) drive(1'b1, (k == 0), W'(8'hA0 + k));
    for (int k = 0; k < N; k++) drive(1'b1, (k == 0), W'(8'hC0 + k));
    for (int k = 0; k < 5; k++) drive(1'b1, (k == 0), W'(8'hB0 + k));
    drive(1'b1, 1'b1, 8'hE0);
    for (int k = 1; k < N; k++) drive(1'b1, 1'b0, W'(8'hE0 + k));

    // R9: idle cycle with inSol high and a junk pixel mid-line
    ph = "R9";
    for (int k = 0; k < 4; k++) drive(1'b1, (k == 0), W'(8'h50 + k));
    drive(1'b0, 1'b1, 8'hFF);
    drive(1'b0, 1'b1, 8'hEE);
    for (int k = 4; k < N; k++) drive(1'b1, 1'b0, W'(8'h50 + k));

    // mixed random tail, then drain
    ph = "R1";
    for (int l = 0; l < 20; l++) sendLine(int'($urandom % 40));
    for (int i = 0; i < 2 * N + 2; i++) drive(1'b0, 1'b0, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule